// File: doc/BRIEF.md
# Reference Clock Presence and Accuracy Monitor

This block checks two 10 MHz clocks at the same time against a 100 MHz system clock. One is generated on the board and the other arrives from outside. Software sets a measurement window length in system clock cycles. Over each window the block counts the rising edges of both 10 MHz clocks. When the window closes, each count is compared with a programmable pass band and the channel is marked good or bad. A new window then starts at once, with no software trigger.

Each 10 MHz clock drives a Gray-coded counter in its own clock domain. The system domain synchronizes that counter and samples it at the window edges. Software reads the gate length, the two limits, the two status bits, the last captured counts, the interrupt enable and the interrupt flag. A change in either status bit sets the flag. The flag stays set until software writes a 1 to it. The interrupt output is the flag gated by the enable bit.

Top module: `ref_freq_monitor`

## Requirements
- R1: Each channel's captured count is the number of rising edges of its 10 MHz clock seen during one window of exactly GATE system cycles. It can be read at address 4 (internal) and address 5 (external).
- R2: A channel's status bit is 1 only when its count is strictly greater than the lower limit (address 1) and strictly less than the upper limit (address 2). A count equal to either limit gives 0. The status register is at address 3: bit 0 is the internal channel and bit 1 is the external channel.
- R3: When a clock is absent, its count is 0 and its status bit is 0, whatever the limits are.
- R4: While GATE (address 0) is nonzero, windows repeat without a break. Status and counts update only at the end of a window, once every GATE cycles, with no software trigger.
- R5: Writing GATE = 0 stops measurement. Status and captured counts keep their last values.
- R6: The interrupt flag (address 7, bit 0) is set at the end of any window where at least one status bit changes. A window with no change leaves the flag as it is.
- R7: Writing a 1 to bit 0 at address 7 clears the flag. Writing a 0 has no effect. If a set and a clear happen in the same cycle, the set wins.
- R8: The irq output equals the flag ANDed with the enable bit (address 6, bit 0). The flag still latches while the enable bit is 0.
- R9: After reset, every register reads 0 and irq is 0.
- R10: Both channels are measured over the same window and judged independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock and time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_int_clk | input | 1 | Internally generated 10 MHz clock |
| ref_ext_clk | input | 1 | External 10 MHz clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| irq | output | 1 | Masked status-change interrupt |

## Verification
The hardest part is getting exact counts and a well-defined pass band edge. Counts pass through a synchronizer of several cycles, and a reference clock that drifts against the time base moves the count by one from window to window. The bench places every reference clock edge 3 ns away from a system edge and uses window lengths that are whole multiples of the 10-cycle period. This makes the accurate channels give exact counts, so the limits can be set equal to the count to test both boundaries. The off-frequency and absent clocks are switched only while measurement is stopped, so every window sees one clock condition. Their limits sit far from the possible counts, so the one-count uncertainty cannot change the status.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_INT = 0;
  localparam int CH_EXT = 1;

  typedef enum logic [2:0] {
    REG_GATE     = 3'd0,
    REG_LO       = 3'd1,
    REG_HI       = 3'd2,
    REG_STATUS   = 3'd3,
    REG_CNT_INT  = 3'd4,
    REG_CNT_EXT  = 3'd5,
    REG_IRQ_EN   = 3'd6,
    REG_IRQ_FLAG = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/rfm_rst_sync.sv
// Reset asserted asynchronously, released on the second local edge.
module rfm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rfm_gray_cnt.sv
// Free-running edge counter in the reference domain, Gray output registered.
module rfm_gray_cnt #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] bin_q, bin_d, gray_q, gray_d;

  always_comb begin
    bin_d  = bin_q + W'(1);
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;
endmodule

// File: rtl/rfm_gray_sync.sv
// Two-flop synchronizer for a Gray bus, followed by conversion to binary.
module rfm_gray_sync #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_g2b
    assign bin_o[g] = ^s2_q[W-1:g];
  end
endmodule

// File: rtl/rfm_meas_chan.sv
// One measurement channel: counts in its own domain, differenced in clk domain.
module rfm_meas_chan #(
  parameter int CNT_W = 20
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             clk,
  input  logic             sys_rst_n,
  input  logic             track,
  input  logic             win_end,
  output logic [CNT_W-1:0] meas_o
);
  logic             ref_rst_n;
  logic [CNT_W-1:0] gray_ref;
  logic [CNT_W-1:0] cur_bin;
  logic [CNT_W-1:0] base_q, base_d;
  logic             base_en;

  rfm_rst_sync u_rst (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .rst_sync_n (ref_rst_n)
  );

  rfm_gray_cnt #(.W(CNT_W)) u_cnt (
    .clk    (ref_clk),
    .rst_n  (ref_rst_n),
    .gray_o (gray_ref)
  );

  rfm_gray_sync #(.W(CNT_W)) u_sync (
    .clk    (clk),
    .rst_n  (sys_rst_n),
    .gray_i (gray_ref),
    .bin_o  (cur_bin)
  );

  always_comb begin
    base_en = track || win_end;
    base_d  = base_en ? cur_bin : base_q;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) base_q <= '0;
    else            base_q <= base_d;
  end

  assign meas_o = cur_bin - base_q;
endmodule

// File: rtl/rfm_gate_timer.sv
// Window timer: a pulse every GATE cycles, idle while GATE is zero.
module rfm_gate_timer #(
  parameter int GATE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GATE_W-1:0] gate,
  output logic              idle,
  output logic              win_end
);
  logic [GATE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    idle    = (gate == '0);
    win_end = !idle && (cnt_q >= gate - GATE_W'(1));
    cnt_d   = (idle || win_end) ? '0 : cnt_q + GATE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ref_freq_monitor.sv
module ref_freq_monitor
  import rfm_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int GATE_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_int_clk,
  input  logic              ref_ext_clk,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic                            sys_rst_n;
  logic [NUM_CH-1:0]               ref_clk_vec;
  logic [NUM_CH-1:0][CNT_W-1:0]    meas;
  logic [NUM_CH-1:0]               good;
  logic                            gate_idle, win_end;

  logic [GATE_W-1:0]               gate_q, gate_d;
  logic [CNT_W-1:0]                lo_q, lo_d, hi_q, hi_d;
  logic [NUM_CH-1:0]               status_q, status_d;
  logic [NUM_CH-1:0][CNT_W-1:0]    cnt_q, cnt_d;
  logic                            irq_en_q, irq_en_d;
  logic                            irq_flag_q, irq_flag_d;
  logic                            flag_set, clr_req;
  reg_addr_e                       addr;
  logic                            unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:GATE_W];
  assign addr         = reg_addr_e'(reg_addr);
  assign ref_clk_vec[CH_INT] = ref_int_clk;
  assign ref_clk_vec[CH_EXT] = ref_ext_clk;

  rfm_rst_sync u_sys_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (sys_rst_n)
  );

  rfm_gate_timer #(.GATE_W(GATE_W)) u_timer (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .gate    (gate_q),
    .idle    (gate_idle),
    .win_end (win_end)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    rfm_meas_chan #(.CNT_W(CNT_W)) u_chan (
      .ref_clk   (ref_clk_vec[ch]),
      .rst_n     (rst_n),
      .clk       (clk),
      .sys_rst_n (sys_rst_n),
      .track     (gate_idle),
      .win_end   (win_end),
      .meas_o    (meas[ch])
    );
    assign good[ch] = (meas[ch] > lo_q) && (meas[ch] < hi_q);
  end

  // next-state
  always_comb begin
    gate_d   = gate_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    irq_en_d = irq_en_q;
    status_d = status_q;
    cnt_d    = cnt_q;
    clr_req  = 1'b0;

    if (reg_wr) begin
      case (addr)
        REG_GATE:     gate_d   = reg_wdata[GATE_W-1:0];
        REG_LO:       lo_d     = reg_wdata[CNT_W-1:0];
        REG_HI:       hi_d     = reg_wdata[CNT_W-1:0];
        REG_IRQ_EN:   irq_en_d = reg_wdata[0];
        REG_IRQ_FLAG: clr_req  = reg_wdata[0];
        default:      ;
      endcase
    end

    if (win_end) begin
      status_d = good;
      cnt_d    = meas;
    end

    flag_set = win_end && (good != status_q);
    if (flag_set)     irq_flag_d = 1'b1;
    else if (clr_req) irq_flag_d = 1'b0;
    else              irq_flag_d = irq_flag_q;
  end

  // registers
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      gate_q     <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      irq_en_q   <= 1'b0;
      status_q   <= '0;
      cnt_q      <= '0;
      irq_flag_q <= 1'b0;
    end else begin
      gate_q     <= gate_d;
      lo_q       <= lo_d;
      hi_q       <= hi_d;
      irq_en_q   <= irq_en_d;
      status_q   <= status_d;
      cnt_q      <= cnt_d;
      irq_flag_q <= irq_flag_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (addr)
      REG_GATE:     reg_rdata[GATE_W-1:0] = gate_q;
      REG_LO:       reg_rdata[CNT_W-1:0]  = lo_q;
      REG_HI:       reg_rdata[CNT_W-1:0]  = hi_q;
      REG_STATUS:   reg_rdata[NUM_CH-1:0] = status_q;
      REG_CNT_INT:  reg_rdata[CNT_W-1:0]  = cnt_q[CH_INT];
      REG_CNT_EXT:  reg_rdata[CNT_W-1:0]  = cnt_q[CH_EXT];
      REG_IRQ_EN:   reg_rdata[0]          = irq_en_q;
      REG_IRQ_FLAG: reg_rdata[0]          = irq_flag_q;
      default:      ;
    endcase
  end

  assign irq = irq_flag_q & irq_en_q;
endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
  parameter int CNT_W  = 20,
  parameter int GATE_W = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gate_idle,
  input logic                 win_end,
  input logic [1:0]           status_q,
  input logic [1:0][CNT_W-1:0] cnt_q,
  input logic [1:0][CNT_W-1:0] meas,
  input logic [GATE_W-1:0]    gate_q,
  input logic                 irq_flag_q,
  input logic                 irq_en_q,
  input logic                 flag_set,
  input logic                 clr_req,
  input logic                 irq
);
  // R4: status moves only on a window end
  assert_status_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(status_q));

  // R5: stopped measurement holds captured counts
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_idle && gate_q == '0) |=> $stable(cnt_q));

  // R3: zero count on either channel reports bad
  assert_zero_int_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && meas[0] == '0) |=> !status_q[0]);
  assert_zero_ext_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && meas[1] == '0) |=> !status_q[1]);

  // R6: any status change leaves the flag set
  assert_flag_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_q) |-> irq_flag_q);

  // R7: write-one clear takes effect when no set competes
  assert_flag_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !flag_set) |=> !irq_flag_q);

  // R8: no interrupt while disabled
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q |-> !irq);
endmodule

bind ref_freq_monitor rfm_checker #(.CNT_W(CNT_W), .GATE_W(GATE_W)) u_chk (
  .clk        (clk),
  .rst_n      (sys_rst_n),
  .gate_idle  (gate_idle),
  .win_end    (win_end),
  .status_q   (status_q),
  .cnt_q      (cnt_q),
  .meas       (meas),
  .gate_q     (gate_q),
  .irq_flag_q (irq_flag_q),
  .irq_en_q   (irq_en_q),
  .flag_set   (flag_set),
  .clr_req    (clr_req),
  .irq        (irq)
);

// File: tb/ref_freq_monitor_tb.sv
`timescale 1ns/1ps
module ref_freq_monitor_tb;
  localparam int DATA_W = 32;
  localparam logic [2:0] A_GATE = 3'd0, A_LO = 3'd1, A_HI = 3'd2, A_STATUS = 3'd3,
                         A_CINT = 3'd4, A_CEXT = 3'd5, A_EN = 3'd6, A_FLAG = 3'd7;

  logic              clk, rst_n, ref_int_clk, ref_ext_clk;
  logic              reg_wr;
  logic [2:0]        reg_addr;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;
  int ext_mode = 1;          // 0 absent, 1 accurate, 2 off-frequency
  bit done = 0;

  ref_freq_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .ref_int_clk(ref_int_clk), .ref_ext_clk(ref_ext_clk),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  initial begin clk = 0; forever #5 clk = ~clk; end
  initial begin ref_int_clk = 0; #3; forever #50 ref_int_clk = ~ref_int_clk; end
  initial begin
    ref_ext_clk = 0; #3;
    forever begin
      if (ext_mode == 0) begin ref_ext_clk = 0; #10; end
      else begin
        if (ext_mode == 1) #50; else #55;
        ref_ext_clk = ~ref_ext_clk;
      end
    end
  end

  // behavioural reference model
  int m_gate, m_lo, m_hi, m_pos;
  bit m_en, m_flag;
  bit [1:0] m_status;

  function automatic int est_count(int period, int gate);
    if (period == 0) return 0;
    return gate / period;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gate = 0; m_lo = 0; m_hi = 0; m_pos = 0;
      m_en = 0; m_flag = 0; m_status = 0;
    end else begin
      bit ended, setf;
      bit [1:0] ng;
      int ci, ce;
      ended = 0; setf = 0;
      if (m_gate != 0) begin
        if (m_pos >= m_gate - 1) begin ended = 1; m_pos = 0; end
        else m_pos++;
      end else m_pos = 0;
      if (ended) begin
        ci = est_count(10, m_gate);
        ce = est_count(ext_mode == 0 ? 0 : (ext_mode == 1 ? 10 : 11), m_gate);
        ng[0] = (ci > m_lo) && (ci < m_hi);
        ng[1] = (ce > m_lo) && (ce < m_hi);
        if (ng != m_status) setf = 1;
        m_status = ng;
      end
      if (setf) m_flag = 1;
      else if (reg_wr && reg_addr == A_FLAG && reg_wdata[0]) m_flag = 0;
      if (reg_wr) begin
        case (reg_addr)
          A_GATE: m_gate = int'(reg_wdata[23:0]);
          A_LO:   m_lo   = int'(reg_wdata[19:0]);
          A_HI:   m_hi   = int'(reg_wdata[19:0]);
          A_EN:   m_en   = reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison (R4 timing, R6, R8)
  always begin
    @(negedge clk); #2;
    if (rst_n && !done) begin
      checks++;
      if (irq !== (m_flag & m_en)) begin
        errors++;
        $display("FAIL R8/R6 irq per-clock: actual=%0b expected=%0b at %0t", irq, m_flag & m_en, $time);
      end
      if (!reg_wr && reg_addr == A_STATUS) begin
        checks++;
        if (reg_rdata[1:0] !== m_status) begin
          errors++;
          $display("FAIL R4 status per-clock: actual=%0b expected=%0b at %0t", reg_rdata[1:0], m_status, $time);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = DATA_W'(d);
    @(negedge clk);
    reg_wr = 0; reg_addr = A_STATUS; reg_wdata = '0;
  endtask

  task automatic rd_check(input logic [2:0] a, input int exp_lo, input int exp_hi, input string req);
    int v;
    @(negedge clk);
    reg_addr = a; #1;
    v = int'(reg_rdata);
    checks++;
    if (v < exp_lo || v > exp_hi) begin
      errors++;
      $display("FAIL %s addr %0d: actual=%0d expected=%0d..%0d", req, a, v, exp_lo, exp_hi);
    end
    #2 reg_addr = A_STATUS;
  endtask

  task automatic chk(input bit cond, input int act, input int exp, input string req);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = A_STATUS; reg_wdata = '0;
    cycles(5);
    rst_n = 1;
    cycles(5);
    // R9: reset state
    for (int a = 0; a < 8; a++) rd_check(3'(a), 0, 0, "R9 reset value");
    #1 chk(irq == 1'b0, irq, 0, "R9 irq after reset");

    // R1/R2/R10: accurate clocks in band
    wr(A_LO, 95); wr(A_HI, 105); wr(A_EN, 1);
    wr(A_GATE, 1000);
    cycles(2100);
    rd_check(A_STATUS, 3, 3, "R10 both channels good");
    rd_check(A_CINT, 100, 100, "R1 internal count");
    rd_check(A_CEXT, 100, 100, "R1 external count");
    rd_check(A_FLAG, 1, 1, "R6 flag after status change");
    #1 chk(irq == 1'b1, irq, 1, "R8 irq when enabled");

    // R7: write 0 ignored, write 1 clears
    wr(A_FLAG, 0);
    rd_check(A_FLAG, 1, 1, "R7 write zero ignored");
    wr(A_FLAG, 1);
    rd_check(A_FLAG, 0, 0, "R7 write one clears");
    cycles(1100);
    rd_check(A_FLAG, 0, 0, "R6 no change no flag");

    // R5: stop holds state; switch ext to off-frequency while stopped
    wr(A_GATE, 0);
    ext_mode = 2;
    cycles(1500);
    rd_check(A_STATUS, 3, 3, "R5 status held while stopped");
    rd_check(A_CEXT, 100, 100, "R5 count held while stopped");
    wr(A_GATE, 1000);
    cycles(1100);
    rd_check(A_STATUS, 1, 1, "R10 only external bad when off-frequency");
    rd_check(A_CEXT, 89, 92, "R1 off-frequency count");
    rd_check(A_FLAG, 1, 1, "R6 flag on external change");
    wr(A_FLAG, 1);

    // R3: absent clock
    wr(A_GATE, 0); ext_mode = 0; cycles(30);
    wr(A_LO, 0); wr(A_HI, 1000);
    wr(A_GATE, 1000);
    cycles(1100);
    rd_check(A_CEXT, 0, 0, "R3 absent count zero");
    rd_check(A_STATUS, 1, 1, "R3 absent clock bad despite wide band");
    rd_check(A_FLAG, 0, 0, "R6 unchanged status no flag");

    // R8: flag latches while masked
    wr(A_EN, 0);
    wr(A_GATE, 0); ext_mode = 1; cycles(30);
    wr(A_LO, 95); wr(A_HI, 105);
    wr(A_GATE, 1000);
    cycles(1100);
    rd_check(A_STATUS, 3, 3, "R10 external recovered");
    rd_check(A_FLAG, 1, 1, "R8 flag latches while masked");
    #1 chk(irq == 1'b0, irq, 0, "R8 irq masked");
    wr(A_EN, 1);
    #1 chk(irq == 1'b1, irq, 1, "R8 irq after enable");
    wr(A_FLAG, 1);
    #1 chk(irq == 1'b0, irq, 0, "R7 irq drops after clear");

    // R2: boundaries with exact count 50
    wr(A_GATE, 0); cycles(30);
    wr(A_LO, 50); wr(A_HI, 60);
    wr(A_GATE, 500);
    cycles(600);
    rd_check(A_CINT, 50, 50, "R1 internal count gate 500");
    rd_check(A_STATUS, 0, 0, "R2 count equal lower limit is bad");
    wr(A_LO, 40); wr(A_HI, 50);
    cycles(520);
    rd_check(A_STATUS, 0, 0, "R2 count equal upper limit is bad");
    wr(A_LO, 49); wr(A_HI, 51);
    cycles(520);
    rd_check(A_STATUS, 3, 3, "R2 count just inside band is good");

    // R4: windows keep running with no trigger
    wr(A_FLAG, 1);
    wr(A_HI, 50);
    cycles(520);
    rd_check(A_STATUS, 0, 0, "R4 automatic repeat picks up new limit");
    rd_check(A_CEXT, 50, 50, "R4 repeated window count");
    rd_check(A_FLAG, 1, 1, "R6 flag on both channels change");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule